// File: doc/BRIEF.md
# Random Number Generator Command and Status Controller

This block sits on a simple single-cycle register bus and drives a random number generator. Software starts one of two timed operations by writing a command word: a self-test or a seed generation. While either runs, a busy flag is high. When it ends, a done flag is set for that operation, and software clears it with a write-one command. Once a seed has completed, an output FIFO fills one 32-bit word per cycle from a placeholder LFSR entropy source. Software drains the FIFO through a data port and reads the fill level from the status word.

Reads from an empty FIFO follow a policy that software selects in the control word. The read can return zero and record an error, raise a bus fault, or return zero and raise an interrupt. Error causes stay latched until a clear-error command. A software-reset command returns the block to its post-reset state. An optional mode starts a fresh seed by itself after a programmed number of words has been produced. A single interrupt line combines the done flags and the error summary, each class under its own mask.

Top module: `rng_ctrl`

## Requirements
- R1: After reset, status reads with only the FIFO size field (bits 15:12 = DEPTH) set, control reads 0 and `irq` is low.
- R2: Offset 0x00 reads the VERSION_WORD parameter. Offset 0x04 (command) always reads 0. Writing a command word of 0 changes nothing.
- R3: Writing command bit 0 while idle starts a self-test. Status bit 1 (busy) is high for exactly OP_CYCLES cycles. Status bit 4 (self-test done) is set in the first cycle after busy falls.
- R4: Writing command bit 1 while idle starts a seed generation with the same timing. Its end sets status bit 5 (seed done).
- R5: The FIFO receives words only after a seed has completed. It gains one word per cycle while not busy, until status bits 11:8 reach DEPTH.
- R6: Each read of offset 0x14 with words present returns a nonzero word that differs from the previous one. That read lowers the level by one.
- R7: With control bits 1:0 equal to 0 or 1, reading an empty FIFO returns 0 and sets error bit 4 (offset 0x10) and status bit 16. Both stay set until command bit 5 is written.
- R8: With control bits 1:0 equal to 2, reading an empty FIFO asserts `bus_err` and returns 0, and records no error.
- R9: With control bits 1:0 equal to 3, reading an empty FIFO returns 0 and raises `irq` without any error. Command bit 4 clears that interrupt.
- R10: Command bit 4 clears both done flags. Command bit 5 clears the error register and status bit 16.
- R11: `irq` is high when a done flag or the underflow interrupt is set and control bit 5 is 0, or when status bit 16 is set and control bit 6 is 0.
- R12: Command bit 6 aborts any running operation, empties the FIFO, clears the seeded state, all flags, all errors and the control word.
- R13: With control bit 4 set, a seed operation starts by itself once RESEED_WORDS words have entered the FIFO since the last completed seed.
- R14: Start commands written while busy are ignored. When bits 0 and 1 are both written, only the self-test starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| bus_err | output | 1 | Transfer fault for an empty-FIFO read under policy 2 |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench first sweeps all four underflow policies against an empty FIFO, which shows whether zero data, the latched error, the bus fault and the interrupt line each respond only to the policy that owns them. It times self-test and seed runs started from idle, started during a busy window, and started by a combined command word, which separates the start-ignore rule from the priority rule. It then drains the FIFO one word at a time and back-to-back, which shows that push and pop coincide correctly at the full boundary. Auto-reseed is run below and at the word threshold, and a software reset is issued in the middle of an operation.

// File: rtl/rng_ctrl_pkg.sv
package rng_ctrl_pkg;

   localparam int unsigned DATA_W = 32;

   // register byte offsets
   localparam logic [7:0] OFF_VER  = 8'h00;
   localparam logic [7:0] OFF_CMD  = 8'h04;
   localparam logic [7:0] OFF_CTL  = 8'h08;
   localparam logic [7:0] OFF_STAT = 8'h0C;
   localparam logic [7:0] OFF_ERR  = 8'h10;
   localparam logic [7:0] OFF_DATA = 8'h14;

   // command word bits
   localparam int CMD_TEST    = 0;
   localparam int CMD_SEED    = 1;
   localparam int CMD_CLR_INT = 4;
   localparam int CMD_CLR_ERR = 5;
   localparam int CMD_SRST    = 6;

   // control word bits
   localparam int CTL_AUTO  = 4;
   localparam int CTL_MDONE = 5;
   localparam int CTL_MERR  = 6;

   // status word bits
   localparam int ST_BUSY   = 1;
   localparam int ST_TDONE  = 4;
   localparam int ST_SDONE  = 5;
   localparam int ST_LVL_LO = 8;
   localparam int ST_SZ_LO  = 12;
   localparam int ST_ERR    = 16;

   // error cause bit for an underflowing read
   localparam int ERR_UFLOW = 4;

   typedef enum logic [1:0] {
      UF_ZERO_ERR   = 2'd0,
      UF_ZERO_ERR_B = 2'd1,
      UF_BUS_FAULT  = 2'd2,
      UF_ZERO_IRQ   = 2'd3
   } uf_policy_t;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_TEST = 2'd1,
      OP_SEED = 2'd2
   } op_t;

   typedef struct packed {
      logic       mask_err;
      logic       mask_done;
      logic       auto_seed;
      uf_policy_t policy;
   } ctl_t;

endpackage

// File: rtl/rng_ctrl_lfsr.sv
module rng_ctrl_lfsr #(
   parameter int unsigned     W    = 32,
   parameter logic [W-1:0]    TAPS = 32'hA300_0000,
   parameter logic [W-1:0]    SEED = 32'h1D87_2B41
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] value
);

   if (SEED == '0) begin : g_bad_seed
      $error("rng_ctrl_lfsr: SEED must be nonzero");
   end

   logic [W-1:0] shifted;

   always_comb begin
      shifted = value >> 1;
      if (value[0]) shifted = shifted ^ TAPS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    value <= SEED;
      else if (step) value <= shifted;
   end

endmodule

// File: rtl/rng_ctrl_seq.sv
module rng_ctrl_seq
   import rng_ctrl_pkg::*;
#(
   parameter int unsigned OP_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic abort,
   input  logic start_test,
   input  logic start_seed,
   output logic busy,
   output logic test_fin,
   output logic seed_fin
);

   localparam int CNT_W = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;

   if (OP_CYCLES < 1) begin : g_bad_len
      $error("rng_ctrl_seq: OP_CYCLES must be at least 1");
   end

   op_t              op_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last;

   assign busy     = (op_q != OP_IDLE);
   assign last     = busy && (cnt_q == '0);
   assign test_fin = last && (op_q == OP_TEST);
   assign seed_fin = last && (op_q == OP_SEED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q  <= OP_IDLE;
         cnt_q <= '0;
      end else if (abort) begin
         op_q  <= OP_IDLE;
         cnt_q <= '0;
      end else if (!busy) begin
         if (start_test) begin
            op_q  <= OP_TEST;
            cnt_q <= CNT_W'(OP_CYCLES - 1);
         end else if (start_seed) begin
            op_q  <= OP_SEED;
            cnt_q <= CNT_W'(OP_CYCLES - 1);
         end
      end else if (last) begin
         op_q <= OP_IDLE;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/rng_ctrl_fifo.sv
module rng_ctrl_fifo #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 8,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [W-1:0]     wdata,
   input  logic             pop,
   output logic [W-1:0]     rdata,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty
);

   localparam int  PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit  POW2  = (DEPTH == (1 << PTR_W));

   if (DEPTH < 2) begin : g_bad_depth
      $error("rng_ctrl_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

endmodule

// File: rtl/rng_ctrl.sv
module rng_ctrl
   import rng_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W       = 6,
   parameter int unsigned DEPTH        = 8,
   parameter int unsigned OP_CYCLES    = 16,
   parameter int unsigned RESEED_WORDS = 64,
   parameter logic [31:0] VERSION_WORD = 32'h3A01_0203
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_err,
   output logic              irq
);

   localparam int LVL_W = $clog2(DEPTH + 1);
   localparam int WC_W  = $clog2(RESEED_WORDS + 1);

   if (DEPTH < 2 || DEPTH > 15) begin : g_bad_depth
      $error("rng_ctrl: DEPTH must lie in 2..15 to fit the level field");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("rng_ctrl: ADDR_W too narrow for the register map");
   end
   if (RESEED_WORDS < 1) begin : g_bad_reseed
      $error("rng_ctrl: RESEED_WORDS must be at least 1");
   end

   // ---------------- decode
   logic acc_rd, acc_wr;
   logic cmd_wr, ctl_wr, data_rd;
   logic soft_rst, clr_int, clr_err, req_test, req_seed;

   assign acc_rd   = bus_valid && !bus_write;
   assign acc_wr   = bus_valid && bus_write;
   assign cmd_wr   = acc_wr && (bus_addr == ADDR_W'(OFF_CMD));
   assign ctl_wr   = acc_wr && (bus_addr == ADDR_W'(OFF_CTL));
   assign data_rd  = acc_rd && (bus_addr == ADDR_W'(OFF_DATA));
   assign soft_rst = cmd_wr && bus_wdata[CMD_SRST];
   assign clr_int  = cmd_wr && bus_wdata[CMD_CLR_INT];
   assign clr_err  = cmd_wr && bus_wdata[CMD_CLR_ERR];
   assign req_test = cmd_wr && bus_wdata[CMD_TEST] && !soft_rst;
   assign req_seed = cmd_wr && bus_wdata[CMD_SEED] && !soft_rst;

   logic unused_wdata;
   assign unused_wdata = ^{bus_wdata[31:7], bus_wdata[3:2]};

   // ---------------- state
   ctl_t             ctl_q;
   logic             seeded_q, tdone_q, sdone_q, uf_int_q, err_uflow_q;
   logic [WC_W-1:0]  word_cnt;

   logic             busy, test_fin, seed_fin, auto_trig;
   logic             push, pop, under, full, empty;
   logic [LVL_W-1:0] level;
   logic [31:0]      fifo_q, entropy;
   logic             uf_err, uf_bus, uf_irq;
   logic             err_sum;
   logic [31:0]      status_w, error_w, ctl_w;

   assign auto_trig = ctl_q.auto_seed && seeded_q && !busy &&
                      (word_cnt == WC_W'(RESEED_WORDS));
   assign push      = seeded_q && !busy && !full && !auto_trig;
   assign pop       = data_rd && !empty;
   assign under     = data_rd && empty;

   assign uf_err = under && (ctl_q.policy == UF_ZERO_ERR || ctl_q.policy == UF_ZERO_ERR_B);
   assign uf_bus = under && (ctl_q.policy == UF_BUS_FAULT);
   assign uf_irq = under && (ctl_q.policy == UF_ZERO_IRQ);

   // ---------------- sub-blocks
   rng_ctrl_seq #(.OP_CYCLES(OP_CYCLES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .abort      (soft_rst),
      .start_test (req_test),
      .start_seed (req_seed || auto_trig),
      .busy       (busy),
      .test_fin   (test_fin),
      .seed_fin   (seed_fin)
   );

   rng_ctrl_lfsr #(.W(DATA_W)) u_src (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (push),
      .value (entropy)
   );

   rng_ctrl_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (soft_rst),
      .push  (push),
      .wdata (entropy),
      .pop   (pop),
      .rdata (fifo_q),
      .level (level),
      .full  (full),
      .empty (empty)
   );

   // ---------------- control word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (soft_rst) begin
         ctl_q <= '0;
      end else if (ctl_wr) begin
         ctl_q.policy    <= uf_policy_t'(bus_wdata[1:0]);
         ctl_q.auto_seed <= bus_wdata[CTL_AUTO];
         ctl_q.mask_done <= bus_wdata[CTL_MDONE];
         ctl_q.mask_err  <= bus_wdata[CTL_MERR];
      end
   end

   // ---------------- flags: a set in the same cycle outranks a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seeded_q    <= 1'b0;
         tdone_q     <= 1'b0;
         sdone_q     <= 1'b0;
         uf_int_q    <= 1'b0;
         err_uflow_q <= 1'b0;
      end else if (soft_rst) begin
         seeded_q    <= 1'b0;
         tdone_q     <= 1'b0;
         sdone_q     <= 1'b0;
         uf_int_q    <= 1'b0;
         err_uflow_q <= 1'b0;
      end else begin
         if (seed_fin) seeded_q <= 1'b1;

         if (test_fin)     tdone_q <= 1'b1;
         else if (clr_int) tdone_q <= 1'b0;

         if (seed_fin)     sdone_q <= 1'b1;
         else if (clr_int) sdone_q <= 1'b0;

         if (uf_irq)       uf_int_q <= 1'b1;
         else if (clr_int) uf_int_q <= 1'b0;

         if (uf_err)       err_uflow_q <= 1'b1;
         else if (clr_err) err_uflow_q <= 1'b0;
      end
   end

   // ---------------- words produced since the last completed seed
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      word_cnt <= '0;
      else if (soft_rst || seed_fin)   word_cnt <= '0;
      else if (push && word_cnt != WC_W'(RESEED_WORDS))
                                       word_cnt <= word_cnt + 1'b1;
   end

   // ---------------- read side
   always_comb begin
      error_w            = '0;
      error_w[ERR_UFLOW] = err_uflow_q;
   end

   assign err_sum = |error_w;

   always_comb begin
      status_w                      = '0;
      status_w[ST_BUSY]             = busy;
      status_w[ST_TDONE]            = tdone_q;
      status_w[ST_SDONE]            = sdone_q;
      status_w[ST_LVL_LO +: 4]      = 4'(level);
      status_w[ST_SZ_LO +: 4]       = 4'(DEPTH);
      status_w[ST_ERR]              = err_sum;
   end

   always_comb begin
      ctl_w            = '0;
      ctl_w[1:0]       = ctl_q.policy;
      ctl_w[CTL_AUTO]  = ctl_q.auto_seed;
      ctl_w[CTL_MDONE] = ctl_q.mask_done;
      ctl_w[CTL_MERR]  = ctl_q.mask_err;
   end

   always_comb begin
      bus_rdata = '0;
      if (acc_rd) begin
         if (bus_addr == ADDR_W'(OFF_VER))       bus_rdata = VERSION_WORD;
         else if (bus_addr == ADDR_W'(OFF_CTL))  bus_rdata = ctl_w;
         else if (bus_addr == ADDR_W'(OFF_STAT)) bus_rdata = status_w;
         else if (bus_addr == ADDR_W'(OFF_ERR))  bus_rdata = error_w;
         else if (bus_addr == ADDR_W'(OFF_DATA)) bus_rdata = empty ? '0 : fifo_q;
      end
   end

   assign bus_err = uf_bus;
   assign irq     = ((tdone_q || sdone_q || uf_int_q) && !ctl_q.mask_done) ||
                    (err_sum && !ctl_q.mask_err);

endmodule

// File: rtl/rng_ctrl_chk.sv
module rng_ctrl_chk #(
   parameter int unsigned DEPTH     = 8,
   parameter int unsigned OP_CYCLES = 16,
   parameter int unsigned LVL_W     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             tdone,
   input logic             sdone,
   input logic [LVL_W-1:0] level,
   input logic             push,
   input logic             pop,
   input logic             seeded,
   input logic             err_sum,
   input logic             clr_err,
   input logic             soft_rst,
   input logic             under,
   input logic             bus_err,
   input logic [1:0]       policy,
   input logic             mask_done,
   input logic             mask_err,
   input logic             irq
);

   localparam int BC_W = $clog2(OP_CYCLES + 1) + 1;

   logic [BC_W-1:0] bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    bcnt <= '0;
      else if (!busy)                bcnt <= '0;
      else if (bcnt != {BC_W{1'b1}}) bcnt <= bcnt + 1'b1;
   end

   assert_busy_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bcnt < BC_W'(OP_CYCLES)));

   assert_done_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(soft_rst)) |-> (tdone || sdone));

   assert_level_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level) <= int'(DEPTH));

   assert_fill_needs_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !seeded |=> (int'(level) <= int'($past(level))));

   assert_pop_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !soft_rst) |=> (int'(level) == int'($past(level)) - 1));

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_sum && !clr_err && !soft_rst) |=> err_sum);

   assert_fault_policy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (under && policy == 2'd2));

   assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_done && mask_err) |-> !irq);

endmodule

bind rng_ctrl rng_ctrl_chk #(
   .DEPTH     (DEPTH),
   .OP_CYCLES (OP_CYCLES),
   .LVL_W     (LVL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .tdone     (tdone_q),
   .sdone     (sdone_q),
   .level     (level),
   .push      (push),
   .pop       (pop),
   .seeded    (seeded_q),
   .err_sum   (err_sum),
   .clr_err   (clr_err),
   .soft_rst  (soft_rst),
   .under     (under),
   .bus_err   (bus_err),
   .policy    (ctl_q.policy),
   .mask_done (ctl_q.mask_done),
   .mask_err  (ctl_q.mask_err),
   .irq       (irq)
);

// File: tb/rng_ctrl_bench.sv
module rng_ctrl_bench;

   localparam int          AW    = 6;
   localparam int          DEPTH = 4;
   localparam int          OPC   = 5;
   localparam int          RSW   = 6;
   localparam logic [31:0] VER   = 32'h5A01_0304;

   localparam logic [7:0] A_VER  = 8'h00;
   localparam logic [7:0] A_CMD  = 8'h04;
   localparam logic [7:0] A_CTL  = 8'h08;
   localparam logic [7:0] A_STAT = 8'h0C;
   localparam logic [7:0] A_ERR  = 8'h10;
   localparam logic [7:0] A_DATA = 8'h14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0;
   logic          bus_write = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_err;
   logic          irq;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   rng_ctrl #(
      .ADDR_W(AW), .DEPTH(DEPTH), .OP_CYCLES(OPC),
      .RESEED_WORDS(RSW), .VERSION_WORD(VER)
   ) u_rng_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .irq(irq)
   );

   function automatic logic [31:0] st(input int bsy, input int td, input int sd,
                                      input int lvl, input int er);
      logic [31:0] v;
      v        = '0;
      v[1]     = bsy[0];
      v[4]     = td[0];
      v[5]     = sd[0];
      v[11:8]  = lvl[3:0];
      v[15:12] = 4'(DEPTH);
      v[16]    = er[0];
      return v;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a[AW-1:0]; bus_wdata = d;
      @(posedge clk);
      #1 bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output logic e);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a[AW-1:0];
      #2 d = bus_rdata; e = bus_err;
      @(posedge clk);
      #1 bus_valid = 1'b0;
   endtask

   task automatic poll_busy(output int nb, output logic [31:0] last);
      logic e;
      nb = 0;
      for (int k = 0; k < 200; k++) begin
         bus_rd(A_STAT, last, e);
         if (!last[1]) break;
         nb++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] d, w0, w1, w2;
      logic        e, saw;
      int          nb;

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 / R2: reset state and identity
      bus_rd(A_STAT, d, e); chk("R1 status after reset", d, st(0, 0, 0, 0, 0));
      bus_rd(A_CTL, d, e);  chk("R1 control after reset", d, 32'h0);
      chk("R1 irq after reset", {31'b0, irq}, 32'h0);
      bus_rd(A_VER, d, e);  chk("R2 version word", d, VER);
      bus_rd(A_CMD, d, e);  chk("R2 command reads zero", d, 32'h0);

      // R7 R8 R9: underflow policy sweep on the unseeded, empty FIFO
      for (int p = 0; p < 4; p++) begin
         bus_wr(A_CTL, 32'(p));
         bus_rd(A_DATA, d, e);
         chk("R7 R8 R9 underflow data zero", d, 32'h0);
         chk("R8 bus fault only under policy 2", {31'b0, e}, {31'b0, (p == 2)});
         chk("R9 R11 irq after underflow", {31'b0, irq}, {31'b0, (p != 2)});
         bus_rd(A_ERR, d, e);
         chk("R7 error bit 4 latched", d, (p <= 1) ? 32'h10 : 32'h0);
         bus_rd(A_STAT, d, e);
         chk("R7 status summary error", d, st(0, 0, 0, 0, (p <= 1)));
         if (p == 0) begin
            bus_wr(A_CMD, 32'h0);
            bus_rd(A_ERR, d, e);
            chk("R2 zero command leaves error", d, 32'h10);
         end
         bus_wr(A_CMD, 32'h30);
         bus_rd(A_ERR, d, e);
         chk("R10 clear error command", d, 32'h0);
         chk("R9 R10 irq cleared", {31'b0, irq}, 32'h0);
      end

      // R11: error mask
      bus_wr(A_CTL, 32'h40);
      bus_rd(A_DATA, d, e);
      chk("R11 masked error keeps irq low", {31'b0, irq}, 32'h0);
      bus_rd(A_ERR, d, e);  chk("R7 masked error still latched", d, 32'h10);
      bus_wr(A_CTL, 32'h0);
      chk("R11 unmasking raises irq", {31'b0, irq}, 32'h1);
      bus_wr(A_CMD, 32'h20);
      chk("R10 irq low after clear", {31'b0, irq}, 32'h0);

      // R3: self-test timing
      bus_wr(A_CMD, 32'h1);
      poll_busy(nb, d);
      chk("R3 busy length", 32'(nb), 32'(OPC));
      chk("R3 self-test done, nothing in FIFO", d, st(0, 1, 0, 0, 0));
      chk("R11 done raises irq", {31'b0, irq}, 32'h1);
      bus_wr(A_CTL, 32'h20);
      chk("R11 done mask", {31'b0, irq}, 32'h0);
      bus_wr(A_CTL, 32'h0);
      bus_wr(A_CMD, 32'h10);
      bus_rd(A_STAT, d, e);
      chk("R10 clear done flags", d, st(0, 0, 0, 0, 0));

      // R4 R14: seed, with an ignored self-test request during busy
      bus_wr(A_CMD, 32'h2);
      bus_wr(A_CMD, 32'h1);
      poll_busy(nb, d);
      chk("R14 start while busy ignored", 32'(nb), 32'(OPC - 1));
      chk("R4 seed done", d, st(0, 0, 1, 0, 0));

      // R5: fill ramp, one word per cycle, capped at DEPTH
      for (int i = 1; i <= DEPTH + 2; i++) begin
         bus_rd(A_STAT, d, e);
         chk("R5 fill level", d, st(0, 0, 1, (i > DEPTH) ? DEPTH : i, 0));
      end

      // R14: both start bits at once
      bus_wr(A_CMD, 32'h10);
      bus_wr(A_CMD, 32'h3);
      poll_busy(nb, d);
      chk("R14 self-test priority length", 32'(nb), 32'(OPC));
      chk("R14 self-test priority flags", d, st(0, 1, 0, DEPTH, 0));
      bus_wr(A_CMD, 32'h10);

      // R6: draining
      bus_rd(A_DATA, w0, e);
      chk("R6 no fault on valid read", {31'b0, e}, 32'h0);
      bus_rd(A_STAT, d, e);  chk("R6 level drops by one", d, st(0, 0, 0, DEPTH - 1, 0));
      bus_rd(A_STAT, d, e);  chk("R5 refill after pop", d, st(0, 0, 0, DEPTH, 0));
      bus_rd(A_DATA, w1, e);
      bus_rd(A_DATA, w2, e);
      bus_rd(A_STAT, d, e);  chk("R6 back-to-back pops", d, st(0, 0, 0, DEPTH - 1, 0));
      chk("R6 words nonzero and changing", {31'b0, (w0 != 0 && w1 != w0 && w2 != w1)}, 32'h1);
      bus_rd(A_STAT, d, e);

      // R13: auto reseed (threshold already passed)
      bus_wr(A_CTL, 32'h10);
      saw = 1'b0;
      for (int i = 0; i < 20; i++) begin
         bus_rd(A_STAT, d, e);
         if (d[1]) saw = 1'b1;
      end
      chk("R13 auto reseed starts", {31'b0, saw}, 32'h1);
      chk("R13 auto reseed completes", d, st(0, 0, 1, DEPTH, 0));
      bus_wr(A_CMD, 32'h10);
      saw = 1'b0;
      for (int i = 0; i < 2; i++) begin
         bus_rd(A_DATA, d, e);
         bus_rd(A_STAT, d, e); if (d[1]) saw = 1'b1;
         bus_rd(A_STAT, d, e); if (d[1]) saw = 1'b1;
      end
      for (int i = 0; i < 10; i++) begin
         bus_rd(A_STAT, d, e); if (d[1]) saw = 1'b1;
      end
      chk("R13 no reseed below threshold", {31'b0, saw}, 32'h0);
      for (int i = 0; i < 4; i++) begin
         bus_rd(A_DATA, d, e);
         bus_rd(A_STAT, d, e); if (d[1]) saw = 1'b1;
         bus_rd(A_STAT, d, e); if (d[1]) saw = 1'b1;
      end
      for (int i = 0; i < 20; i++) begin
         bus_rd(A_STAT, d, e); if (d[1]) saw = 1'b1;
      end
      chk("R13 reseed at threshold", {31'b0, saw}, 32'h1);
      chk("R13 reseed done flag", {31'b0, d[5]}, 32'h1);
      bus_wr(A_CTL, 32'h0);
      bus_wr(A_CMD, 32'h10);

      // R12: software reset in the middle of a self-test
      bus_wr(A_CTL, 32'h73);
      bus_wr(A_CMD, 32'h1);
      bus_wr(A_CMD, 32'h40);
      bus_rd(A_STAT, d, e);  chk("R12 status after soft reset", d, st(0, 0, 0, 0, 0));
      for (int i = 0; i < OPC + 2; i++) bus_rd(A_STAT, d, e);
      chk("R12 no done and no refill later", d, st(0, 0, 0, 0, 0));
      bus_rd(A_CTL, d, e);   chk("R12 control cleared", d, 32'h0);
      chk("R12 irq low", {31'b0, irq}, 32'h0);
      bus_rd(A_DATA, d, e);
      chk("R12 FIFO empty after soft reset", d, 32'h0);
      bus_rd(A_ERR, d, e);   chk("R12 R7 policy back to 0", d, 32'h10);
      bus_wr(A_CMD, 32'h20);
      bus_rd(A_ERR, d, e);   chk("R10 final clear", d, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule